// File: doc/BRIEF.md
# Pad Boundary Scan Chain

This block places one scan cell beside each chip pad and links the cells into a serial chain clocked by the test clock. Each cell holds two bits. The first is a shift stage that forms part of the serial path. The second is a holding stage that keeps a test vector applied while the next vector moves through the chain. The chain length equals the parameter `PADS`.

A test sequence runs in four steps. A capture strobe samples the observed output-pad values into the shift stages. Shift cycles then move the captured results out of `scan_out` and the next vector in from `scan_in`. An update strobe copies the shift stages into the holding stages. While scan mode is active, the holding stages replace the physical input pads on the core side. While scan mode is inactive, the core sees the physical input pads unchanged, and nothing the chain does affects normal operation.

Top module: `pad_bscan_chain`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, every shift stage and holding stage clears to 0 and the registered scan mode clears to inactive. After reset, `scan_out` is 0 and `core_in` equals `pad_in`.
- R2: If `scan_mode` was low at the previous `tck` edge, `core_in` equals `pad_in` bit for bit. Strobes and shifting have no effect on it.
- R3: If `scan_mode` was high at the previous `tck` edge (outside reset), `core_in` equals the holding stages and does not follow `pad_in`.
- R4: When `capture_stb` is high at an edge, shift stage i loads `obs_pad[i]`. `scan_out` then shows `obs_pad[PADS-1]` after that edge.
- R5: When `shift_en` is high and `capture_stb` is low at an edge, `scan_in` enters stage 0 and stage i loads stage i-1. `scan_out` is always stage `PADS-1`.
- R6: After a capture, the k-th following shift edge (k = 1 .. PADS-1) brings captured bit `PADS-1-k` to `scan_out`. To load vector W, the bench drives W[PADS-1] first.
- R7: The holding stages change only on an edge with `update_stb` high, where they take the shift stages' pre-edge contents. Shifting and capture without an update leave them unchanged.
- R8: When `capture_stb` and `shift_en` are both high at an edge, the capture wins and `scan_in` is ignored.
- R9: When neither `capture_stb` nor `shift_en` is high at an edge, every shift stage keeps its value, so `scan_out` is stable.
- R10: An update at the same edge as a shift loads the holding stages with the contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge active |
| trst_n | input | 1 | Synchronous active-low test reset |
| scan_mode | input | 1 | Scan mode select, registered before use |
| shift_en | input | 1 | Move the chain one position per edge |
| capture_stb | input | 1 | Load observed output-pad values into the shift stages |
| update_stb | input | 1 | Copy the shift stages into the holding stages |
| scan_in | input | 1 | Serial input into stage 0 |
| scan_out | output | 1 | Serial output from stage PADS-1 |
| obs_pad | input | PADS | Values present on the output pads |
| pad_in | input | PADS | Values arriving from the physical input pads |
| core_in | output | PADS | Input-pad values delivered to the core |

## Verification
`scan_out` and the holding stages change one rising edge after the cycle that presents a strobe or a shift. The scan mode selection reaches `core_in` one edge after `scan_mode` is driven. `pad_in` reaches `core_in` within the same cycle when scan mode is inactive. The driver applies each cycle's inputs 2 ns after a rising edge and queues the expected outputs, stamped with the current cycle, from a bench-side model that the driver advances after queuing. The monitor samples on the falling edge of the same cycle, so registered results are compared one edge after their stimulus and the combinational pass-through is compared in the cycle it is driven.

// File: rtl/bscan_pkg.sv
// Package: shared types for the pad boundary scan chain.
// Assumes: one operation code per cycle is applied to every shift stage.
package bscan_pkg;

    // Operation applied to the shift stages at the next test clock edge.
    typedef enum logic [1:0] {
        OP_KEEP    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } bsc_op_e;

endpackage

// File: rtl/bsc_ctrl.sv
// Module: bsc_ctrl
// Turns the raw shift enable and capture strobe into one operation code
// shared by all cells, with capture taking priority. Also registers the
// scan mode select so that it is inactive after reset.
// Assumes: all inputs are synchronous to tck.
module bsc_ctrl
    import bscan_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    scan_mode,
    input  logic    shift_en,
    input  logic    capture_stb,
    output bsc_op_e op,
    output logic    mode_q
);

    // Decode the chain operation; capture outranks shift.
    always_comb begin
        if (capture_stb)   op = OP_CAPTURE;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_KEEP;
    end

    // Register the mode select; cleared by test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) mode_q <= 1'b0;
        else         mode_q <= scan_mode;
    end

endmodule

// File: rtl/bsc_cell.sv
// Module: bsc_cell
// One boundary scan cell for a single pad: a shift stage in the serial
// path and a holding stage that drives the core-side input while scan
// mode is active.
// Assumes: op and update_stb are common to every cell of the chain.
module bsc_cell
    import bscan_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  bsc_op_e op,
    input  logic    update_stb,
    input  logic    mode_q,
    input  logic    ser_in,
    input  logic    obs_bit,
    input  logic    pad_bit,
    output logic    chain_bit,
    output logic    hold_bit,
    output logic    core_bit
);

    // Shift stage: capture, shift or keep.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            chain_bit <= 1'b0;
        end else begin
            unique case (op)
                OP_CAPTURE: chain_bit <= obs_bit;
                OP_SHIFT:   chain_bit <= ser_in;
                default:    chain_bit <= chain_bit;
            endcase
        end
    end

    // Holding stage: loads the pre-edge shift stage on update only.
    always_ff @(posedge tck) begin
        if (!trst_n)         hold_bit <= 1'b0;
        else if (update_stb) hold_bit <= chain_bit;
    end

    // Core-side select: held vector in scan mode, else the real pad.
    always_comb core_bit = mode_q ? hold_bit : pad_bit;

endmodule

// File: rtl/pad_bscan_chain.sv
// Module: pad_bscan_chain (top)
// A chain of PADS boundary scan cells. Cell 0 takes scan_in and cell
// PADS-1 drives scan_out. Strobes capture and apply vectors, and the
// registered mode select chooses between the held vector and the pads.
// Assumes: PADS >= 1; every input is synchronous to tck.
module pad_bscan_chain
    import bscan_pkg::*;
#(
    parameter int PADS = 8
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            scan_mode,
    input  logic            shift_en,
    input  logic            capture_stb,
    input  logic            update_stb,
    input  logic            scan_in,
    output logic            scan_out,
    input  logic [PADS-1:0] obs_pad,
    input  logic [PADS-1:0] pad_in,
    output logic [PADS-1:0] core_in
);

    localparam int LAST = PADS - 1;

    bsc_op_e         op;
    logic            mode_q;
    logic [PADS-1:0] chain_q;
    logic [PADS-1:0] hold_q;
    logic [PADS:0]   link;

    bsc_ctrl u_ctrl (
        .tck         (tck),
        .trst_n      (trst_n),
        .scan_mode   (scan_mode),
        .shift_en    (shift_en),
        .capture_stb (capture_stb),
        .op          (op),
        .mode_q      (mode_q)
    );

    // Serial entry into the first cell.
    always_comb link[0] = scan_in;

    for (genvar i = 0; i < PADS; i++) begin : g_cell
        bsc_cell u_cell (
            .tck        (tck),
            .trst_n     (trst_n),
            .op         (op),
            .update_stb (update_stb),
            .mode_q     (mode_q),
            .ser_in     (link[i]),
            .obs_bit    (obs_pad[i]),
            .pad_bit    (pad_in[i]),
            .chain_bit  (chain_q[i]),
            .hold_bit   (hold_q[i]),
            .core_bit   (core_in[i])
        );
        // Forward this cell's shift stage to the next cell.
        always_comb link[i+1] = chain_q[i];
    end

    // Serial output from the last cell.
    always_comb scan_out = link[LAST+1];

endmodule

// File: rtl/pad_bscan_chain_chk.sv
// Module: pad_bscan_chain_chk
// Assertion checker bound into pad_bscan_chain; observes ports plus the
// shift and holding stage buses.
module pad_bscan_chain_chk #(
    parameter int PADS = 8
) (
    input logic            tck,
    input logic            trst_n,
    input logic            scan_mode,
    input logic            shift_en,
    input logic            capture_stb,
    input logic            update_stb,
    input logic            scan_in,
    input logic            scan_out,
    input logic [PADS-1:0] obs_pad,
    input logic [PADS-1:0] pad_in,
    input logic [PADS-1:0] core_in,
    input logic [PADS-1:0] chain_q,
    input logic [PADS-1:0] hold_q
);

    p_reset_clear_r1: assert property (@(posedge tck)
        !trst_n |=> (chain_q == '0 && hold_q == '0 && core_in == pad_in));

    p_pass_through_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (!$past(trst_n) || !$past(scan_mode)) |-> core_in == pad_in);

    p_scan_drive_r3: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(trst_n) && $past(scan_mode)) |-> core_in == hold_q);

    p_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
        capture_stb |=> scan_out == $past(obs_pad[PADS-1]));

    p_shift_entry_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_stb) |=> chain_q[0] == $past(scan_in));

    p_update_load_r7: assert property (@(posedge tck) disable iff (!trst_n)
        update_stb |=> hold_q == $past(chain_q));

    p_hold_frozen_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !update_stb |=> $stable(hold_q));

    p_capture_wins_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_stb && shift_en) |=> chain_q == $past(obs_pad));

    p_idle_keep_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (!capture_stb && !shift_en) |=> $stable(chain_q));

endmodule

bind pad_bscan_chain pad_bscan_chain_chk #(.PADS(PADS)) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .scan_mode   (scan_mode),
    .shift_en    (shift_en),
    .capture_stb (capture_stb),
    .update_stb  (update_stb),
    .scan_in     (scan_in),
    .scan_out    (scan_out),
    .obs_pad     (obs_pad),
    .pad_in      (pad_in),
    .core_in     (core_in),
    .chain_q     (chain_q),
    .hold_q      (hold_q)
);

// File: tb/pad_bscan_chain_bench.sv
// Scoreboard bench: the driver applies one cycle of inputs 2 ns after a
// rising edge and queues expected outputs; the monitor compares on the
// falling edge of the same cycle.
module pad_bscan_chain_bench;

    localparam int PADS = 8;

    typedef struct {
        int              cyc;
        logic            exp_so;
        logic [PADS-1:0] exp_core;
        string           req;
    } exp_t;

    logic            tck = 1'b0;
    logic            trst_n = 1'b0;
    logic            scan_mode = 1'b0;
    logic            shift_en = 1'b0;
    logic            capture_stb = 1'b0;
    logic            update_stb = 1'b0;
    logic            scan_in = 1'b0;
    logic            scan_out;
    logic [PADS-1:0] obs_pad = '0;
    logic [PADS-1:0] pad_in = '0;
    logic [PADS-1:0] core_in;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    // Bench-side model state, advanced from the requirements.
    logic [PADS-1:0] m_chain = '0;
    logic [PADS-1:0] m_hold = '0;
    logic            m_mode = 1'b0;

    pad_bscan_chain #(.PADS(PADS)) u_pad_bscan_chain (
        .tck(tck), .trst_n(trst_n), .scan_mode(scan_mode),
        .shift_en(shift_en), .capture_stb(capture_stb),
        .update_stb(update_stb), .scan_in(scan_in), .scan_out(scan_out),
        .obs_pad(obs_pad), .pad_in(pad_in), .core_in(core_in)
    );

    always #5 tck = ~tck;

    always @(posedge tck) cyc <= cyc + 1;

    // Monitor: pop items due this cycle and compare.
    always @(negedge tck) begin
        while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (scan_out !== e.exp_so) begin
                n_fail++;
                $display("FAIL %s scan_out actual=%b expected=%b", e.req, scan_out, e.exp_so);
            end
            n_run++;
            if (core_in !== e.exp_core) begin
                n_fail++;
                $display("FAIL %s core_in actual=%h expected=%h", e.req, core_in, e.exp_core);
            end
        end
    end

    // Driver: one cycle of stimulus, expectation queued, model advanced.
    task automatic step(input logic rst_n, input logic mode, input logic sh,
                        input logic cap, input logic upd, input logic si,
                        input logic [PADS-1:0] obs, input logic [PADS-1:0] pad,
                        input string req);
        exp_t e;
        @(posedge tck);
        #2;
        trst_n = rst_n; scan_mode = mode; shift_en = sh; capture_stb = cap;
        update_stb = upd; scan_in = si; obs_pad = obs; pad_in = pad;
        e.cyc = cyc;
        e.exp_so = m_chain[PADS-1];
        e.exp_core = m_mode ? m_hold : pad;
        e.req = req;
        exp_q.push_back(e);
        if (!rst_n) begin
            m_chain = '0; m_hold = '0; m_mode = 1'b0;
        end else begin
            if (upd) m_hold = m_chain;
            if (cap)     m_chain = obs;
            else if (sh) m_chain = {m_chain[PADS-2:0], si};
            m_mode = mode;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [PADS-1:0] w;
        // R1: reset clears state, mode inactive.
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 1, 1, '1, 8'h33, "R1");
        step(1, 0, 0, 0, 0, 0, '0, 8'h96, "R1");
        // R2: pass-through with strobes toggling.
        step(1, 0, 0, 0, 1, 0, 8'h11, 8'h5A, "R2");
        step(1, 0, 0, 1, 0, 1, 8'hC3, 8'hFF, "R2");
        step(1, 0, 1, 0, 1, 1, 8'h00, 8'h00, "R2");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h81, "R2");
        // R4: capture A5, R6: shift results out while loading W.
        step(1, 0, 0, 1, 0, 0, 8'hA5, 8'h24, "R4");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h24, "R4");
        w = 8'h3C;
        for (int k = 0; k < PADS; k++)
            step(1, 0, 1, 0, 0, w[PADS-1-k], 8'h00, 8'h24, "R6");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h24, "R5");
        // R7: apply W, R3: scan mode drives core from held vector.
        step(1, 1, 0, 0, 1, 0, 8'h00, 8'hE7, "R7");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'h18, "R3");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'hFF, "R3");
        // R7: shifting and capture without update leave held vector.
        w = 8'hC3;
        for (int k = 0; k < PADS; k++)
            step(1, 1, 1, 0, 0, w[PADS-1-k], 8'h00, 8'h0F, "R7");
        step(1, 1, 0, 1, 0, 0, 8'h5E, 8'hF0, "R7");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'hF0, "R7");
        // R8: capture outranks shift.
        step(1, 1, 1, 1, 0, 0, 8'h81, 8'h00, "R8");
        step(1, 1, 1, 0, 0, 1, 8'h00, 8'h00, "R8");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R8");
        // R9: idle keeps chain while scan_in toggles.
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 0, k[0], 8'hFF, 8'h00, "R9");
        // R10: update coincident with shift takes pre-shift contents.
        step(1, 1, 1, 0, 1, 1, 8'h00, 8'h00, "R10");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R10");
        step(1, 1, 0, 0, 1, 0, 8'h00, 8'h00, "R10");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R10");
        // R5: single-bit walk through the full chain.
        step(1, 0, 1, 0, 0, 1, 8'h00, 8'h00, "R5");
        for (int k = 0; k < PADS; k++) step(1, 0, 1, 0, 0, 0, 8'h00, 8'h3A, "R5");
        // R1: reset mid-run returns to pass-through.
        step(0, 1, 0, 0, 0, 0, 8'h00, 8'h77, "R1");
        step(1, 1, 0, 0, 0, 0, 8'h00, 8'h6B, "R1");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h6B, "R1");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h6B, "R1");
        @(posedge tck);
        @(posedge tck);
        summary();
        $finish;
    end

endmodule